// File: doc/BRIEF.md
# Packet Acquisition Sequencing Controller

This block is a synchronous state machine that steers the receive side of a data modem on a link where the carrier never drops. A quiet carrier and a modulated carrier look the same to a carrier-level detector. The controller therefore works from two baseband flags instead: an envelope-detect flag that rises when modulation appears, and an end-of-packet flag that rises when modulation disappears. It drives the modem's task interface with a level-tracking mode select, a one-clock task strobe with a task code, and two acquisition bits.

While idle, the controller holds the modem in fast lossy-peak level mode and waits. A rising envelope starts acquisition. The controller then waits a fixed number of bit times so that the early error burst can settle, searches for frame sync, and reads a programmed number of blocks. A short loss of envelope during the reads is tolerated. A longer one aborts the packet. After the last block, the controller re-acquires clock timing only, so that a packet sent directly after the last one is still caught.

All timing is counted in received bit times, using a one-cycle `bit_tick` pulse that comes from the modem's bit clock. The settle time and the fade tolerance are parameters with defaults of 11 and 17 bit times.

Top module: `pkt_acq_seq`

## Requirements
- R1: During reset and in the cycle after it, `lvl_avg` is 0 and no strobe is issued. In the first cycle after reset is released, a null task (code 0) is issued with `aq_lvl`=1 and `aq_clk`=0, and the controller then waits armed.
- R2: Only a 0-to-1 change of `env_det`, seen while armed, starts acquisition. The next cycle sets `lvl_avg`=1 and issues a null task with both `aq_lvl` and `aq_clk` set. An envelope that stays high does not start it.
- R3: A search task (code 1) with both acquisition bits cleared is issued only after SETTLE_BITS bit ticks have been counted since the acquisition task.
- R4: Each cycle with `irq` and `buf_free` both high, while waiting for sync or reading, issues a read-block task (code 2). The first read follows sync. Further reads follow until the block count reaches `n_blocks`, and a value of 0 counts as 1.
- R5: The block-done event that follows the `n_blocks`-th read issues a null task with only `aq_clk` set. After a further SETTLE_BITS ticks, a search task follows.
- R6: While reading, `eop_det`=1 with `env_det`=0 starts a fade count, and reading continues. If the flags return to `eop_det`=0 and `env_det`=1 after no more than FADE_BITS ticks, reading resumes with no abort.
- R7: If a fade reaches FADE_BITS+1 ticks, a reset task (code 3) is issued. The next cycle sets `lvl_avg`=0 and issues the re-arming null task with only `aq_lvl` set.
- R8: `eop_det`=1 with `env_det`=0 during settling, sync search or the post-packet settle issues a reset task at once, followed by re-arming.
- R9: Every strobe lasts one clock. Search, read and reset tasks carry both acquisition bits cleared, and the acquisition bits and code hold their values between strobes.
- R10: The settle and fade timers advance only on cycles with `bit_tick` high. Without ticks, no search is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per received bit |
| env_det | input | 1 | Baseband envelope present |
| eop_det | input | 1 | End-of-packet flag |
| irq | input | 1 | Modem interrupt flag |
| buf_free | input | 1 | Modem data buffer ready flag |
| n_blocks | input | BLK_W | Blocks per packet |
| lvl_avg | output | 1 | 1 = peak-averaging level mode, 0 = lossy-peak |
| task_stb | output | 1 | Task write strobe, one clock |
| task_code | output | 2 | 0 null, 1 search, 2 read-block, 3 reset |
| aq_lvl | output | 1 | Level-acquire bit of the task |
| aq_clk | output | 1 | Clock-acquire bit of the task |

## Verification
The controller's state is visible at the ports only through strobes. A wrong phase or counter value therefore shows as a strobe that is missing, early, or carries the wrong code. A timer off by one shifts a search or reset strobe by one bit-tick interval. A wrong block count adds or drops a read strobe at the packet's end. A wrong phase after an abort shows in the very next cycle, as a missing re-arming null task. The bench runs a behavioural model alongside the design and compares every output on every clock, so any such divergence is reported in the cycle where it first appears at a port.

// File: rtl/acq_pkg.sv
// Shared types of the packet acquisition sequencer.
// Assumes: task codes are fixed by the modem's task register.
package acq_pkg;

    typedef enum logic [1:0] {
        TASK_NULL   = 2'd0,
        TASK_SEARCH = 2'd1,
        TASK_READ   = 2'd2,
        TASK_RESET  = 2'd3
    } task_e;

    typedef enum logic [2:0] {
        ST_REARM,
        ST_ARMED,
        ST_SETTLE,
        ST_SYNC,
        ST_READ,
        ST_FADE,
        ST_CONCAT
    } state_e;

endpackage

// File: rtl/acq_rise_det.sv
// Rising-edge detector for the envelope flag.
// Assumes: the flag is already synchronous to clk.
module acq_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    // Remember the previous sample of the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/acq_tick_timer.sv
// Saturating bit-time counter. Cleared by clr, advanced by tick,
// reports done once LIMIT ticks have been counted since the clear.
// Assumes: clr has priority over tick in the same cycle.
module acq_tick_timer #(
    parameter int LIMIT = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    // Count ticks up to the limit and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (clr)                  cnt <= '0;
        else if (tick && cnt != LIM)   cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIM);
endmodule

// File: rtl/acq_blk_cnt.sv
// Counts read tasks issued in the current packet and flags the last one.
// Assumes: load marks the first read; a target of 0 behaves like 1.
module acq_blk_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         inc,
    input  logic [W-1:0] target,
    output logic         last
);
    logic [W-1:0] cnt;

    // Track the number of reads issued, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= W'(1);
        else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
    end

    assign last = (cnt >= target);
endmodule

// File: rtl/acq_seq_fsm.sv
// Sequencing state machine: chooses the next phase and the task to
// issue. All task outputs are registered, and a strobe lasts one clock.
// Assumes: timers and block counter are cleared via the *_clr/load
// outputs in the same cycle the phase changes.
module acq_seq_fsm
    import acq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  env_det,
    input  logic  eop_det,
    input  logic  env_rise,
    input  logic  irq,
    input  logic  buf_free,
    input  logic  settle_done,
    input  logic  fade_done,
    input  logic  blk_last,
    output logic  settle_clr,
    output logic  fade_clr,
    output logic  blk_load,
    output logic  blk_inc,
    output logic  lvl_avg,
    output logic  task_stb,
    output task_e task_code,
    output logic  aq_lvl,
    output logic  aq_clk
);
    state_e st, st_nx;
    logic   avg_nx;
    logic   iss;
    task_e  iss_code;
    logic   iss_al, iss_ac;
    logic   lost, blk_ev, back;

    assign lost   = eop_det & ~env_det;
    assign back   = ~eop_det & env_det;
    assign blk_ev = irq & buf_free;

    // Next phase and task decision for the current cycle.
    always_comb begin
        st_nx      = st;
        avg_nx     = lvl_avg;
        iss        = 1'b0;
        iss_code   = TASK_NULL;
        iss_al     = 1'b0;
        iss_ac     = 1'b0;
        settle_clr = 1'b0;
        fade_clr   = 1'b0;
        blk_load   = 1'b0;
        blk_inc    = 1'b0;
        case (st)
            ST_REARM: begin
                avg_nx = 1'b0;
                iss    = 1'b1;
                iss_al = 1'b1;
                st_nx  = ST_ARMED;
            end
            ST_ARMED: begin
                if (env_rise) begin
                    avg_nx     = 1'b1;
                    iss        = 1'b1;
                    iss_al     = 1'b1;
                    iss_ac     = 1'b1;
                    settle_clr = 1'b1;
                    st_nx      = ST_SETTLE;
                end
            end
            ST_SETTLE, ST_CONCAT: begin
                if (lost) begin
                    iss      = 1'b1;
                    iss_code = TASK_RESET;
                    st_nx    = ST_REARM;
                end else if (settle_done) begin
                    iss      = 1'b1;
                    iss_code = TASK_SEARCH;
                    st_nx    = ST_SYNC;
                end
            end
            ST_SYNC: begin
                if (lost) begin
                    iss      = 1'b1;
                    iss_code = TASK_RESET;
                    st_nx    = ST_REARM;
                end else if (blk_ev) begin
                    iss      = 1'b1;
                    iss_code = TASK_READ;
                    blk_load = 1'b1;
                    st_nx    = ST_READ;
                end
            end
            ST_READ, ST_FADE: begin
                if (st == ST_FADE && fade_done) begin
                    iss      = 1'b1;
                    iss_code = TASK_RESET;
                    st_nx    = ST_REARM;
                end else if (blk_ev) begin
                    iss = 1'b1;
                    if (blk_last) begin
                        iss_ac     = 1'b1;
                        settle_clr = 1'b1;
                        st_nx      = ST_CONCAT;
                    end else begin
                        iss_code = TASK_READ;
                        blk_inc  = 1'b1;
                    end
                end else if (st == ST_READ && lost) begin
                    fade_clr = 1'b1;
                    st_nx    = ST_FADE;
                end else if (st == ST_FADE && back) begin
                    st_nx = ST_READ;
                end
            end
            default: st_nx = ST_REARM;
        endcase
    end

    // Register the phase, the level mode and the task outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_REARM;
            lvl_avg   <= 1'b0;
            task_stb  <= 1'b0;
            task_code <= TASK_NULL;
            aq_lvl    <= 1'b0;
            aq_clk    <= 1'b0;
        end else begin
            st       <= st_nx;
            lvl_avg  <= avg_nx;
            task_stb <= iss;
            if (iss) begin
                task_code <= iss_code;
                aq_lvl    <= iss_al;
                aq_clk    <= iss_ac;
            end
        end
    end
endmodule

// File: rtl/pkt_acq_seq.sv
// Top of the packet acquisition sequencer: wires the envelope edge
// detector, settle and fade timers, block counter and state machine.
// Assumes: all inputs are synchronous to clk; bit_tick is one clock wide.
module pkt_acq_seq #(
    parameter int SETTLE_BITS = 11,
    parameter int FADE_BITS   = 17,
    parameter int BLK_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             env_det,
    input  logic             eop_det,
    input  logic             irq,
    input  logic             buf_free,
    input  logic [BLK_W-1:0] n_blocks,
    output logic             lvl_avg,
    output logic             task_stb,
    output logic [1:0]       task_code,
    output logic             aq_lvl,
    output logic             aq_clk
);
    import acq_pkg::*;

    localparam int FADE_LIMIT = FADE_BITS + 1;

    logic  env_rise;
    logic  settle_clr, settle_done;
    logic  fade_clr, fade_done;
    logic  blk_load, blk_inc, blk_last;
    task_e code_e;

    acq_rise_det u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (env_det),
        .rise  (env_rise)
    );

    acq_tick_timer #(.LIMIT(SETTLE_BITS)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (settle_clr),
        .tick  (bit_tick),
        .done  (settle_done)
    );

    acq_tick_timer #(.LIMIT(FADE_LIMIT)) u_fade (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fade_clr),
        .tick  (bit_tick),
        .done  (fade_done)
    );

    acq_blk_cnt #(.W(BLK_W)) u_blk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (blk_load),
        .inc    (blk_inc),
        .target (n_blocks),
        .last   (blk_last)
    );

    acq_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .env_det     (env_det),
        .eop_det     (eop_det),
        .env_rise    (env_rise),
        .irq         (irq),
        .buf_free    (buf_free),
        .settle_done (settle_done),
        .fade_done   (fade_done),
        .blk_last    (blk_last),
        .settle_clr  (settle_clr),
        .fade_clr    (fade_clr),
        .blk_load    (blk_load),
        .blk_inc     (blk_inc),
        .lvl_avg     (lvl_avg),
        .task_stb    (task_stb),
        .task_code   (code_e),
        .aq_lvl      (aq_lvl),
        .aq_clk      (aq_clk)
    );

    assign task_code = code_e;
endmodule

// File: rtl/acq_seq_chk.sv
// Port-level properties of the packet acquisition sequencer.
// Assumes: bound to pkt_acq_seq; observes its ports only.
module acq_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       env_det,
    input logic       irq,
    input logic       buf_free,
    input logic       lvl_avg,
    input logic       task_stb,
    input logic [1:0] task_code,
    input logic       aq_lvl,
    input logic       aq_clk
);
    // Reset leaves the level mode lossy and no strobe.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!task_stb && !lvl_avg));

    // A full acquisition task follows an envelope that was high.
    assert_acq_after_env_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (task_stb && task_code == 2'd0 && aq_lvl && aq_clk) |-> (lvl_avg && $past(env_det)));

    // A search task runs in averaging mode with both bits clear.
    assert_search_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (task_stb && task_code == 2'd1) |-> (!aq_lvl && !aq_clk && lvl_avg));

    // A read only follows a cycle with interrupt and free buffer.
    assert_read_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (task_stb && task_code == 2'd2) |-> $past(irq && buf_free));

    // A null task without level acquire is the clock-only re-arm.
    assert_clock_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (task_stb && task_code == 2'd0 && !aq_lvl) |-> (aq_clk && lvl_avg));

    // A reset task is followed at once by the re-arming null task.
    assert_rearm_after_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (task_stb && task_code == 2'd3) |=> (task_stb && task_code == 2'd0 && aq_lvl && !aq_clk && !lvl_avg));

    // Non-null tasks carry no acquisition bits.
    assert_plain_task_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (task_stb && task_code != 2'd0) |-> (!aq_lvl && !aq_clk));

    // Outside a strobe the task fields stay put.
    assert_fields_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !task_stb |=> (task_stb || ($stable(task_code) && $stable(aq_lvl) && $stable(aq_clk))));
endmodule

bind pkt_acq_seq acq_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .env_det   (env_det),
    .irq       (irq),
    .buf_free  (buf_free),
    .lvl_avg   (lvl_avg),
    .task_stb  (task_stb),
    .task_code (task_code),
    .aq_lvl    (aq_lvl),
    .aq_clk    (aq_clk)
);

// File: tb/sim_pkt_acq_seq.sv
// Bench: behavioural reference model compared on every clock, plus
// scenario checks on strobe counts.
module sim_pkt_acq_seq;
    localparam int SETTLE = 11;
    localparam int FADE   = 17;
    localparam int PH_REARM = 0, PH_ARMED = 1, PH_SETTLE = 2, PH_SYNC = 3,
                   PH_READ = 4, PH_FADE = 5, PH_CONCAT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       env_det = 1'b1, eop_det = 1'b0, irq = 1'b0, buf_free = 1'b0;
    logic [7:0] n_blocks = 8'd3;
    logic       tick_en = 1'b0, auto_tick = 1'b0, man_tick = 1'b0;
    logic       bit_tick;
    logic       lvl_avg, task_stb, aq_lvl, aq_clk;
    logic [1:0] task_code;

    int checks = 0, errors = 0, cyc = 0, tdiv = 0;
    int n_null_lvl = 0, n_null_both = 0, n_null_clk = 0, n_search = 0, n_read = 0, n_reset = 0, n_bad = 0;
    bit finished = 0;

    // Model state.
    int    ph = PH_REARM, scnt = 0, fcnt = 0, blk = 0;
    logic  m_avg = 0, m_stb = 0, m_al = 0, m_ac = 0, env_prev = 0;
    logic [1:0] m_code = 0;
    string m_req = "R1";

    assign bit_tick = auto_tick | man_tick;

    always #2 clk = ~clk;

    pkt_acq_seq u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .env_det(env_det),
        .eop_det(eop_det), .irq(irq), .buf_free(buf_free), .n_blocks(n_blocks),
        .lvl_avg(lvl_avg), .task_stb(task_stb), .task_code(task_code),
        .aq_lvl(aq_lvl), .aq_clk(aq_clk)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Free-running tick: one pulse every four clocks when enabled.
    always @(negedge clk) begin
        tdiv <= (tdiv + 1) % 4;
        auto_tick <= tick_en && (tdiv == 3);
    end

    // Reference model, advanced at each rising edge from the inputs.
    always @(posedge clk) begin : model
        logic lost, ev, iss, ial, iac, clr_s, clr_f;
        logic [1:0] ic;
        lost = eop_det && !env_det;
        ev = irq && buf_free;
        iss = 0; ial = 0; iac = 0; ic = 0; clr_s = 0; clr_f = 0;
        if (!rst_n) begin
            ph = PH_REARM; scnt = 0; fcnt = 0; blk = 0;
            m_avg = 0; m_stb = 0; m_code = 0; m_al = 0; m_ac = 0; env_prev = 0; m_req = "R1";
        end else begin
            if (ph == PH_REARM) begin
                m_avg = 0; iss = 1; ial = 1; ph = PH_ARMED; m_req = "R1";
            end else if (ph == PH_ARMED) begin
                if (env_det && !env_prev) begin
                    m_avg = 1; iss = 1; ial = 1; iac = 1; clr_s = 1; ph = PH_SETTLE; m_req = "R2";
                end
            end else if (ph == PH_SETTLE || ph == PH_CONCAT || ph == PH_SYNC) begin
                if (lost) begin
                    iss = 1; ic = 3; ph = PH_REARM; m_req = "R8";
                end else if (ph != PH_SYNC && scnt == SETTLE) begin
                    iss = 1; ic = 1; ph = PH_SYNC; m_req = "R3";
                end else if (ph == PH_SYNC && ev) begin
                    iss = 1; ic = 2; blk = 1; ph = PH_READ; m_req = "R4";
                end
            end else begin
                if (ph == PH_FADE && fcnt == FADE + 1) begin
                    iss = 1; ic = 3; ph = PH_REARM; m_req = "R7";
                end else if (ev) begin
                    iss = 1;
                    if (blk >= n_blocks) begin
                        iac = 1; clr_s = 1; ph = PH_CONCAT; m_req = "R5";
                    end else begin
                        ic = 2; if (blk < 255) blk++; m_req = "R4";
                    end
                end else if (ph == PH_READ && lost) begin
                    clr_f = 1; ph = PH_FADE; m_req = "R6";
                end else if (ph == PH_FADE && !eop_det && env_det) begin
                    ph = PH_READ; m_req = "R6";
                end
            end
            m_stb = iss;
            if (iss) begin m_code = ic; m_al = ial; m_ac = iac; end
            if (clr_s) scnt = 0; else if (bit_tick && scnt < SETTLE) scnt++;
            if (clr_f) fcnt = 0; else if (bit_tick && fcnt < FADE + 1) fcnt++;
            env_prev = env_det;
        end
    end

    // Compare every output with the model and tally strobes (R9 fields).
    always @(negedge clk) begin
        if (rst_n || cyc > 1) begin
            chk({m_req, "/R9"}, {lvl_avg, task_stb, task_code, aq_lvl, aq_clk},
                {m_avg, m_stb, m_code, m_al, m_ac});
        end
        if (task_stb) begin
            case (task_code)
                2'd0: if (aq_lvl && aq_clk) n_null_both++; else if (aq_lvl) n_null_lvl++; else n_null_clk++;
                2'd1: n_search++;
                2'd2: n_read++;
                default: n_reset++;
            endcase
            if (task_code != 2'd0 && (aq_lvl || aq_clk)) n_bad++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            wrap_up();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sample();
        @(posedge clk); #1;
    endtask

    task automatic blk_event();
        @(negedge clk); irq = 1; buf_free = 1;
        @(negedge clk); irq = 0; buf_free = 0;
        step(3);
    endtask

    task automatic pulse_ticks(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); man_tick = 1;
            @(negedge clk); man_tick = 0;
        end
    endtask

    initial begin
        step(4);
        sample();
        chk("R1", {lvl_avg, task_stb}, 0);
        @(negedge clk); rst_n = 1;
        step(2);
        sample();
        chk("R1", n_null_lvl, 1);
        // Envelope high since reset: must not start acquisition.
        step(20);
        sample();
        chk("R2", n_null_both, 0);
        // No ticks: rise the envelope, settling must not finish.
        @(negedge clk); env_det = 0;
        step(2); env_det = 1;
        step(3);
        sample();
        chk("R2", {n_null_both, lvl_avg}, {32'd1, 1'b1});
        step(40);
        sample();
        chk("R10", n_search, 0);
        @(negedge clk); tick_en = 1;
        step(60);
        sample();
        chk("R3", n_search, 1);
        // Block reads, N = 3.
        for (int b = 0; b < 4; b++) blk_event();
        sample();
        chk("R4", n_read, 3);
        chk("R5", n_null_clk, 1);
        step(60);
        sample();
        chk("R5", n_search, 2);
        // Fade of exactly FADE ticks is tolerated.
        blk_event();
        @(negedge clk); tick_en = 0;
        step(4);
        @(negedge clk); eop_det = 1; env_det = 0;
        step(2);
        pulse_ticks(FADE);
        step(3);
        @(negedge clk); eop_det = 0; env_det = 1;
        step(3);
        sample();
        chk("R6", n_reset, 0);
        blk_event();
        sample();
        chk("R6", n_read, 5);
        // Fade of FADE+1 ticks aborts.
        @(negedge clk); eop_det = 1; env_det = 0;
        step(2);
        pulse_ticks(FADE + 1);
        step(3);
        sample();
        chk("R7", n_reset, 1);
        chk("R7", n_null_lvl, 2);
        chk("R7", lvl_avg, 0);
        // Loss of envelope during settling aborts at once.
        @(negedge clk); eop_det = 0; env_det = 1; tick_en = 1;
        step(10);
        @(negedge clk); eop_det = 1; env_det = 0;
        step(3);
        sample();
        chk("R8", n_reset, 2);
        chk("R9", n_bad, 0);
        step(5);
        wrap_up();
    end
endmodule